// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the software-visible state of a 64-source interrupt controller. It sits on a simple word-addressed bus: a request is a valid strobe, a write flag, a word index and a 32-bit data word. Read data appears on the clock after a read request. The block holds these registers:

- a control word
- a normal-interrupt mask level
- the per-source enable and type (normal or fast) vectors
- eight packed priority words
- the pending vector

The current state is driven out to a separate priority resolver.

Each raw interrupt input changes its pending bit when its level changes. Software can also overwrite either half of the pending vector directly. Reads of the normal or fast vector words return what the resolver reports. When the resolver reports a valid source, that source's pending bit is cleared as part of the read. Enables can be changed one source at a time by writing a source number, or 32 at a time through the split high and low words.

Top module: `irq_reg_bank`

## Requirements
- R1: After reset the pending, enable, type, control and all priority words are zero, and the mask level is 0x1F.
- R2: A write to index 1 loads data bits 4:0 into the mask level, and a read of index 1 returns it.
- R3: A write to index 2 sets the enable bit numbered by data bits 5:0. A write to index 3 clears that bit. Reads of both indices return zero.
- R4: Indices 4 and 5 are the upper and lower 32 enable bits. Indices 6 and 7 are the upper and lower 32 type bits, where 1 means fast. All four are read/write.
- R5: Index k, for k from 8 to 15, is priority word 15-k. Word w holds sources 8w to 8w+7, with source s in bits 4*(s mod 8)+3 down to 4*(s mod 8). On the prioFlat port, word w sits at bits 32w+31 down to 32w.
- R6: Indices 20 and 21 read zero. A write to them replaces the upper or lower half of the pending vector.
- R7: Indices 18 and 19 read the upper and lower pending halves. Indices 22 and 23 read pending&enable&~type. Indices 24 and 25 read pending&enable&type. In each pair the upper half comes first.
- R8: Writes to indices 16 to 19, 22 to 25, 0x40 and any undefined index change no state. Index 0x40 reads 0x4, and any undefined index reads zero.
- R9: A control write keeps data bits 6:0 and zeroes the rest. Bit 6 is the abort flag. It is forced to zero when the written bit 5 (abort-flag enable) is one; otherwise it takes the written value.
- R10: A rising input level sets that source's pending bit and a falling one clears it. With no edge, force write or vector clear, the pending bit holds.
- R11: A read of index 16 with the normal resolver valid returns (source << 16) | priority and clears that source's pending bit. Without a valid source it returns 0xFFFFFFFF and changes nothing.
- R12: A read of index 17 with the fast resolver valid returns the source number and clears its pending bit. Without a valid source it returns 0xFFFFFFFF.
- R13: When a vector-read clear and an input rising edge hit the same source in one cycle, the pending bit ends at zero.
- R14: Read data is updated on the clock edge that takes a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus request strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irqIn | input | 64 | Raw interrupt levels |
| nvecValid | input | 1 | Resolver has a normal source |
| nvecSrc | input | 6 | Resolver's normal source number |
| nvecPrio | input | 4 | Resolver's normal source priority |
| fvecValid | input | 1 | Resolver has a fast source |
| fvecSrc | input | 6 | Resolver's fast source number |
| pendingVec | output | 64 | Pending vector |
| enableVec | output | 64 | Enable vector |
| typeVec | output | 64 | Type vector, 1 = fast |
| prioFlat | output | 256 | Eight priority words, word w at bits 32w+31 down to 32w |
| maskLevel | output | 5 | Normal mask level |
| ctrlWord | output | 32 | Control word |

## Verification
Some properties are checked on every cycle:

- read data, the mask, the enables and the types hold when nothing addresses them;
- at most one write strobe is active at a time;
- a granted vector read always leaves the cleared source at zero, even against a same-cycle rising edge;
- a control write with the abort enable set leaves the flag at zero.

The bench's scenarios cover the rest. These are the index-to-word mapping of the priority words, the reversed order of that mapping, and the masking of enable numbers to six bits. They also cover the exact vector read encodings, the empty-resolver value, and the stability of state after ignored writes. A behavioural reference model compares every output on every cycle.

// File: rtl/irq_reg_pkg.sv
package irq_reg_pkg;
  localparam int DATA_W     = 32;
  localparam int SRC_N      = 2 * DATA_W;
  localparam int SRC_W      = $clog2(SRC_N);
  localparam int PRIO_W     = 4;
  localparam int PRIO_WORDS = SRC_N * PRIO_W / DATA_W;
  localparam int PSEL_W     = $clog2(PRIO_WORDS);
  localparam int MASK_W     = 5;
  localparam int ADDR_W     = 10;
  localparam int NVEC_SHIFT = 16;

  localparam logic [MASK_W-1:0] MASK_RESET = '1;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h0000_007F;
  localparam int ABORT_EN_BIT   = 5;
  localparam int ABORT_FLAG_BIT = 6;
  localparam logic [DATA_W-1:0] MAGIC_VAL = 32'h4;
  localparam logic [DATA_W-1:0] NO_VEC    = '1;

  localparam logic [ADDR_W-1:0] IDX_CTRL    = 10'd0;
  localparam logic [ADDR_W-1:0] IDX_MASK    = 10'd1;
  localparam logic [ADDR_W-1:0] IDX_EN_NUM  = 10'd2;
  localparam logic [ADDR_W-1:0] IDX_DIS_NUM = 10'd3;
  localparam logic [ADDR_W-1:0] IDX_EN_HI   = 10'd4;
  localparam logic [ADDR_W-1:0] IDX_EN_LO   = 10'd5;
  localparam logic [ADDR_W-1:0] IDX_TY_HI   = 10'd6;
  localparam logic [ADDR_W-1:0] IDX_TY_LO   = 10'd7;
  localparam logic [ADDR_W-1:0] IDX_PRIO_LO = 10'd8;
  localparam logic [ADDR_W-1:0] IDX_PRIO_HI = IDX_PRIO_LO + ADDR_W'(PRIO_WORDS - 1);
  localparam logic [ADDR_W-1:0] IDX_NVEC    = 10'd16;
  localparam logic [ADDR_W-1:0] IDX_FVEC    = 10'd17;
  localparam logic [ADDR_W-1:0] IDX_SRC_HI  = 10'd18;
  localparam logic [ADDR_W-1:0] IDX_SRC_LO  = 10'd19;
  localparam logic [ADDR_W-1:0] IDX_FRC_HI  = 10'd20;
  localparam logic [ADDR_W-1:0] IDX_FRC_LO  = 10'd21;
  localparam logic [ADDR_W-1:0] IDX_NRM_HI  = 10'd22;
  localparam logic [ADDR_W-1:0] IDX_NRM_LO  = 10'd23;
  localparam logic [ADDR_W-1:0] IDX_FST_HI  = 10'd24;
  localparam logic [ADDR_W-1:0] IDX_FST_LO  = 10'd25;
  localparam logic [ADDR_W-1:0] IDX_MAGIC   = 10'd64;

  typedef enum logic [4:0] {
    RD_ZERO, RD_CTRL, RD_MASK, RD_EN_HI, RD_EN_LO, RD_TY_HI, RD_TY_LO,
    RD_PRIO, RD_NVEC, RD_FVEC, RD_PEND_HI, RD_PEND_LO, RD_NRM_HI,
    RD_NRM_LO, RD_FST_HI, RD_FST_LO, RD_MAGIC
  } rdSel_e;

  typedef struct packed {
    logic              wrCtrl;
    logic              wrMask;
    logic              wrEnNum;
    logic              wrDisNum;
    logic              wrEnHi;
    logic              wrEnLo;
    logic              wrTyHi;
    logic              wrTyLo;
    logic              wrPrio;
    logic              wrFrcHi;
    logic              wrFrcLo;
    logic              rdReq;
    logic              rdNvec;
    logic              rdFvec;
    logic [PSEL_W-1:0] prioSel;
    rdSel_e            rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           st
);
  logic isWr, isRd, inPrio;

  assign isWr   = busValid && busWrite;
  assign isRd   = busValid && !busWrite;
  assign inPrio = (busAddr >= IDX_PRIO_LO) && (busAddr <= IDX_PRIO_HI);

  always_comb begin
    st         = '0;
    st.rdSel   = RD_ZERO;
    st.rdReq   = isRd;
    // reversed order: the highest index selects word 0
    st.prioSel = PSEL_W'(IDX_PRIO_HI - busAddr);
    if (inPrio) begin
      st.wrPrio = isWr;
      st.rdSel  = RD_PRIO;
    end else begin
      case (busAddr)
        IDX_CTRL:    begin st.wrCtrl  = isWr; st.rdSel = RD_CTRL;   end
        IDX_MASK:    begin st.wrMask  = isWr; st.rdSel = RD_MASK;   end
        IDX_EN_NUM:  st.wrEnNum  = isWr;
        IDX_DIS_NUM: st.wrDisNum = isWr;
        IDX_EN_HI:   begin st.wrEnHi  = isWr; st.rdSel = RD_EN_HI;  end
        IDX_EN_LO:   begin st.wrEnLo  = isWr; st.rdSel = RD_EN_LO;  end
        IDX_TY_HI:   begin st.wrTyHi  = isWr; st.rdSel = RD_TY_HI;  end
        IDX_TY_LO:   begin st.wrTyLo  = isWr; st.rdSel = RD_TY_LO;  end
        IDX_NVEC:    begin st.rdNvec  = isRd; st.rdSel = RD_NVEC;   end
        IDX_FVEC:    begin st.rdFvec  = isRd; st.rdSel = RD_FVEC;   end
        IDX_SRC_HI:  st.rdSel = RD_PEND_HI;
        IDX_SRC_LO:  st.rdSel = RD_PEND_LO;
        IDX_FRC_HI:  st.wrFrcHi = isWr;
        IDX_FRC_LO:  st.wrFrcLo = isWr;
        IDX_NRM_HI:  st.rdSel = RD_NRM_HI;
        IDX_NRM_LO:  st.rdSel = RD_NRM_LO;
        IDX_FST_HI:  st.rdSel = RD_FST_HI;
        IDX_FST_LO:  st.rdSel = RD_FST_LO;
        IDX_MAGIC:   st.rdSel = RD_MAGIC;
        default:     st.rdSel = RD_ZERO;
      endcase
    end
  end

  // R8: one bus operation never produces two state-changing strobes
  p_single_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrCtrl, st.wrMask, st.wrEnNum, st.wrDisNum, st.wrEnHi, st.wrEnLo,
              st.wrTyHi, st.wrTyLo, st.wrPrio, st.wrFrcHi, st.wrFrcLo,
              st.rdNvec, st.rdFvec}));
endmodule

// File: rtl/irq_reg_state.sv
module irq_reg_state
  import irq_reg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      st,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [SRC_N-1:0]             irqIn,
  input  logic                         nvecValid,
  input  logic [SRC_W-1:0]             nvecSrc,
  input  logic [PRIO_W-1:0]            nvecPrio,
  input  logic                         fvecValid,
  input  logic [SRC_W-1:0]             fvecSrc,
  output logic [DATA_W-1:0]            rdData,
  output logic [SRC_N-1:0]             pendingVec,
  output logic [SRC_N-1:0]             enableVec,
  output logic [SRC_N-1:0]             typeVec,
  output logic [PRIO_WORDS*DATA_W-1:0] prioFlat,
  output logic [MASK_W-1:0]            maskLevel,
  output logic [DATA_W-1:0]            ctrlWord
);
  logic [SRC_N-1:0]  pendQ, pendNext, irqPrevQ, enQ, enNext, tyQ, tyNext;
  logic [SRC_N-1:0]  normView, fastView;
  logic [DATA_W-1:0] ctrlQ, ctrlNext, rdNext, nvecWord, fvecWord;
  logic [MASK_W-1:0] maskQ;
  logic [DATA_W-1:0] prioQ [PRIO_WORDS];

  always_comb begin
    pendNext = (pendQ | (irqIn & ~irqPrevQ)) & ~(~irqIn & irqPrevQ);
    if (st.wrFrcHi) pendNext[SRC_N-1:DATA_W] = wdata;
    if (st.wrFrcLo) pendNext[DATA_W-1:0]     = wdata;
    if (st.rdNvec && nvecValid) pendNext[nvecSrc] = 1'b0;
    if (st.rdFvec && fvecValid) pendNext[fvecSrc] = 1'b0;
  end

  always_comb begin
    enNext = enQ;
    if (st.wrEnNum)  enNext[wdata[SRC_W-1:0]] = 1'b1;
    if (st.wrDisNum) enNext[wdata[SRC_W-1:0]] = 1'b0;
    if (st.wrEnHi)   enNext[SRC_N-1:DATA_W]   = wdata;
    if (st.wrEnLo)   enNext[DATA_W-1:0]       = wdata;
    tyNext = tyQ;
    if (st.wrTyHi)   tyNext[SRC_N-1:DATA_W]   = wdata;
    if (st.wrTyLo)   tyNext[DATA_W-1:0]       = wdata;
    ctrlNext = wdata & CTRL_KEEP;
    if (ctrlNext[ABORT_EN_BIT] && wdata[ABORT_FLAG_BIT]) ctrlNext[ABORT_FLAG_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      irqPrevQ <= '0;
      enQ      <= '0;
      tyQ      <= '0;
      ctrlQ    <= '0;
      maskQ    <= MASK_RESET;
    end else begin
      pendQ    <= pendNext;
      irqPrevQ <= irqIn;
      enQ      <= enNext;
      tyQ      <= tyNext;
      if (st.wrCtrl) ctrlQ <= ctrlNext;
      if (st.wrMask) maskQ <= wdata[MASK_W-1:0];
    end
  end

  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_prio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioQ[w] <= '0;
      else if (st.wrPrio && st.prioSel == PSEL_W'(w)) prioQ[w] <= wdata;
    end
    assign prioFlat[w*DATA_W +: DATA_W] = prioQ[w];
  end

  assign normView = pendQ & enQ & ~tyQ;
  assign fastView = pendQ & enQ & tyQ;
  assign nvecWord = nvecValid ? ((DATA_W'(nvecSrc) << NVEC_SHIFT) | DATA_W'(nvecPrio)) : NO_VEC;
  assign fvecWord = fvecValid ? DATA_W'(fvecSrc) : NO_VEC;

  always_comb begin
    case (st.rdSel)
      RD_CTRL:    rdNext = ctrlQ;
      RD_MASK:    rdNext = DATA_W'(maskQ);
      RD_EN_HI:   rdNext = enQ[SRC_N-1:DATA_W];
      RD_EN_LO:   rdNext = enQ[DATA_W-1:0];
      RD_TY_HI:   rdNext = tyQ[SRC_N-1:DATA_W];
      RD_TY_LO:   rdNext = tyQ[DATA_W-1:0];
      RD_PRIO:    rdNext = prioQ[st.prioSel];
      RD_NVEC:    rdNext = nvecWord;
      RD_FVEC:    rdNext = fvecWord;
      RD_PEND_HI: rdNext = pendQ[SRC_N-1:DATA_W];
      RD_PEND_LO: rdNext = pendQ[DATA_W-1:0];
      RD_NRM_HI:  rdNext = normView[SRC_N-1:DATA_W];
      RD_NRM_LO:  rdNext = normView[DATA_W-1:0];
      RD_FST_HI:  rdNext = fastView[SRC_N-1:DATA_W];
      RD_FST_LO:  rdNext = fastView[DATA_W-1:0];
      RD_MAGIC:   rdNext = MAGIC_VAL;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (st.rdReq) rdData <= rdNext;
  end

  assign pendingVec = pendQ;
  assign enableVec  = enQ;
  assign typeVec    = tyQ;
  assign maskLevel  = maskQ;
  assign ctrlWord   = ctrlQ;

  p_rd_hold_r14: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdReq |=> $stable(rdData));
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrMask |=> $stable(maskLevel));
  p_en_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrEnNum || st.wrDisNum || st.wrEnHi || st.wrEnLo) |=> $stable(enableVec));
  p_type_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrTyHi || st.wrTyLo) |=> $stable(typeVec));
  p_nvec_clear_r13: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdNvec && nvecValid) |=> !pendingVec[$past(nvecSrc)]);
  p_fvec_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdFvec && fvecValid) |=> !pendingVec[$past(fvecSrc)]);
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!st.wrFrcHi && !st.wrFrcLo && !st.rdNvec && !st.rdFvec && irqIn == irqPrevQ)
      |=> $stable(pendingVec));
  p_abort_w1c_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrCtrl && wdata[ABORT_EN_BIT]) |=> !ctrlWord[ABORT_FLAG_BIT]);
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_reg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busValid,
  input  logic                         busWrite,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWdata,
  output logic [DATA_W-1:0]            busRdata,
  input  logic [SRC_N-1:0]             irqIn,
  input  logic                         nvecValid,
  input  logic [SRC_W-1:0]             nvecSrc,
  input  logic [PRIO_W-1:0]            nvecPrio,
  input  logic                         fvecValid,
  input  logic [SRC_W-1:0]             fvecSrc,
  output logic [SRC_N-1:0]             pendingVec,
  output logic [SRC_N-1:0]             enableVec,
  output logic [SRC_N-1:0]             typeVec,
  output logic [PRIO_WORDS*DATA_W-1:0] prioFlat,
  output logic [MASK_W-1:0]            maskLevel,
  output logic [DATA_W-1:0]            ctrlWord
);
  strobe_t st;

  irq_reg_decode u_decode (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .st(st)
  );

  irq_reg_state u_state (
    .clk(clk), .rstN(rstN), .st(st), .wdata(busWdata), .irqIn(irqIn),
    .nvecValid(nvecValid), .nvecSrc(nvecSrc), .nvecPrio(nvecPrio),
    .fvecValid(fvecValid), .fvecSrc(fvecSrc), .rdData(busRdata),
    .pendingVec(pendingVec), .enableVec(enableVec), .typeVec(typeVec),
    .prioFlat(prioFlat), .maskLevel(maskLevel), .ctrlWord(ctrlWord)
  );
endmodule

// File: tb/irq_reg_bank_bench.sv
module irq_reg_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [9:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] irqIn = '0;
  logic nvecValid = 1'b0, fvecValid = 1'b0;
  logic [5:0] nvecSrc = '0, fvecSrc = '0;
  logic [3:0] nvecPrio = '0;
  logic [63:0] pendingVec, enableVec, typeVec;
  logic [255:0] prioFlat;
  logic [4:0] maskLevel;
  logic [31:0] ctrlWord;

  int checks = 0;
  int errors = 0;
  logic [31:0] got;

  irq_reg_bank u_irq_reg_bank (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn),
    .nvecValid(nvecValid), .nvecSrc(nvecSrc), .nvecPrio(nvecPrio),
    .fvecValid(fvecValid), .fvecSrc(fvecSrc), .pendingVec(pendingVec),
    .enableVec(enableVec), .typeVec(typeVec), .prioFlat(prioFlat),
    .maskLevel(maskLevel), .ctrlWord(ctrlWord)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  logic [63:0] mPend, mEn, mTy, mPrev;
  logic [31:0] mPrio [8];
  logic [31:0] mCtrl, mRd;
  logic [4:0]  mMask;

  function automatic logic [31:0] modelRead(int a);
    logic [63:0] nrm, fst;
    nrm = mPend & mEn & ~mTy;
    fst = mPend & mEn & mTy;
    if (a >= 8 && a <= 15) return mPrio[15 - a];
    case (a)
      0:  return mCtrl;
      1:  return {27'd0, mMask};
      4:  return mEn[63:32];
      5:  return mEn[31:0];
      6:  return mTy[63:32];
      7:  return mTy[31:0];
      16: return nvecValid ? ({26'd0, nvecSrc} << 16) | {28'd0, nvecPrio} : 32'hFFFF_FFFF;
      17: return fvecValid ? {26'd0, fvecSrc} : 32'hFFFF_FFFF;
      18: return mPend[63:32];
      19: return mPend[31:0];
      22: return nrm[63:32];
      23: return nrm[31:0];
      24: return fst[63:32];
      25: return fst[31:0];
      64: return 32'h4;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend = '0; mEn = '0; mTy = '0; mPrev = '0; mCtrl = '0; mRd = '0; mMask = 5'h1F;
      for (int i = 0; i < 8; i++) mPrio[i] = '0;
    end else begin
      logic [63:0] np;
      int a;
      a  = int'(busAddr);
      np = mPend;
      for (int i = 0; i < 64; i++) begin
        if (irqIn[i] && !mPrev[i]) np[i] = 1'b1;
        if (!irqIn[i] && mPrev[i]) np[i] = 1'b0;
      end
      mPrev = irqIn;
      if (busValid && !busWrite) begin
        mRd = modelRead(a);
        if (a == 16 && nvecValid) np[nvecSrc] = 1'b0;
        if (a == 17 && fvecValid) np[fvecSrc] = 1'b0;
      end
      if (busValid && busWrite) begin
        if (a >= 8 && a <= 15) mPrio[15 - a] = busWdata;
        case (a)
          0: begin
            mCtrl = busWdata & 32'h7F;
            if (busWdata[5] && busWdata[6]) mCtrl[6] = 1'b0;
          end
          1:  mMask = busWdata[4:0];
          2:  mEn[busWdata[5:0]] = 1'b1;
          3:  mEn[busWdata[5:0]] = 1'b0;
          4:  mEn[63:32] = busWdata;
          5:  mEn[31:0]  = busWdata;
          6:  mTy[63:32] = busWdata;
          7:  mTy[31:0]  = busWdata;
          20: np[63:32]  = busWdata;
          21: np[31:0]   = busWdata;
          default: ;
        endcase
      end
      mPend = np;
    end
  end

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R10 pending vs model", 256'(pendingVec), 256'(mPend));
      check("R3 enable vs model", 256'(enableVec), 256'(mEn));
      check("R4 type vs model", 256'(typeVec), 256'(mTy));
      check("R5 prio vs model", prioFlat,
            {mPrio[7], mPrio[6], mPrio[5], mPrio[4], mPrio[3], mPrio[2], mPrio[1], mPrio[0]});
      check("R2 mask vs model", 256'(maskLevel), 256'(mMask));
      check("R9 ctrl vs model", 256'(ctrlWord), 256'(mCtrl));
      check("R14 rdata vs model", 256'(busRdata), 256'(mRd));
    end
  end

  task automatic busWr(int a, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 10'(a); busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(int a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 10'(a);
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mask reset", 256'(maskLevel), 256'(5'h1F));
    check("R1 pending reset", 256'(pendingVec), 256'(0));
    check("R1 enable/type/ctrl reset", 256'({enableVec, typeVec, ctrlWord}), 256'(0));
    check("R1 prio reset", prioFlat, 256'(0));

    // R2 mask
    busWr(1, 32'hFFFF_FFE3);
    busRd(1, got);
    check("R2 mask readback", 256'(got), 256'(32'h3));

    // R3 enable by number
    busWr(2, 32'd5); busWr(2, 32'd40); busWr(2, 32'h7F);
    check("R3 enable by number", 256'(enableVec),
          256'((64'd1 << 5) | (64'd1 << 40) | (64'd1 << 63)));
    busRd(2, got);
    check("R3 enable-number reads zero", 256'(got), 256'(0));
    busWr(3, 32'h45);
    check("R3 disable by number", 256'(enableVec), 256'((64'd1 << 40) | (64'd1 << 63)));
    busRd(3, got);
    check("R3 disable-number reads zero", 256'(got), 256'(0));

    // R4 split enable/type
    busWr(4, 32'hA5A5_0100); busWr(5, 32'h0000_F0F0);
    busRd(4, got);
    check("R4 enable high", 256'(got), 256'(32'hA5A5_0100));
    busWr(6, 32'h8000_0000); busWr(7, 32'h0000_00F0);
    busRd(7, got);
    check("R4 type low", 256'(got), 256'(32'h0000_00F0));
    check("R4 type vector", 256'(typeVec), 256'(64'h8000_0000_0000_00F0));

    // R5 reversed priority words
    busWr(8, 32'h1111_1111); busWr(15, 32'h89AB_CDEF);
    check("R5 index 8 is word 7", 256'(prioFlat[255:224]), 256'(32'h1111_1111));
    check("R5 index 15 is word 0 (source 1 prio E)", 256'(prioFlat[7:4]), 256'(4'hE));
    busRd(15, got);
    check("R5 index 15 readback", 256'(got), 256'(32'h89AB_CDEF));

    // R6 force
    busWr(21, 32'h0000_00F0); busWr(20, 32'h8000_0100);
    check("R6 force pending", 256'(pendingVec), 256'(64'h8000_0100_0000_00F0));
    busRd(21, got);
    check("R6 force reads zero", 256'(got), 256'(0));

    // R7 views
    busRd(23, got);
    check("R7 normal low", 256'(got), 256'(32'h0));
    busRd(25, got);
    check("R7 fast low", 256'(got), 256'(32'h0000_00F0));
    busRd(22, got);
    check("R7 normal high", 256'(got), 256'(32'h0000_0100));
    busRd(24, got);
    check("R7 fast high", 256'(got), 256'(32'h8000_0000));
    busRd(18, got);
    check("R7 source high", 256'(got), 256'(32'h8000_0100));

    // R8 ignored writes and fixed reads
    busWr(16, '1); busWr(19, '1); busWr(23, '1); busWr(64, '1); busWr(30, '1);
    check("R8 ignored writes keep pending", 256'(pendingVec), 256'(64'h8000_0100_0000_00F0));
    busRd(30, got);
    check("R8 undefined reads zero", 256'(got), 256'(0));
    busRd(64, got);
    check("R8 fixed word", 256'(got), 256'(32'h4));

    // R9 control
    busWr(0, 32'hFFFF_FFDF);
    check("R9 keep bits, flag set without enable", 256'(ctrlWord), 256'(32'h5F));
    busWr(0, 32'h7F);
    check("R9 flag cleared with enable", 256'(ctrlWord), 256'(32'h3F));
    busRd(0, got);
    check("R9 ctrl readback", 256'(got), 256'(32'h3F));

    // R10 input levels
    irqIn[10] = 1'b1; @(negedge clk);
    check("R10 rising sets", 256'(pendingVec[10]), 256'(1));
    busWr(21, 32'h0);
    repeat (2) @(negedge clk);
    check("R10 level held without edge", 256'(pendingVec[10]), 256'(0));
    busWr(21, 32'h400);
    irqIn[10] = 1'b0; @(negedge clk);
    check("R10 falling clears", 256'(pendingVec[10]), 256'(0));

    // R11 normal vector read
    nvecValid = 1'b1; nvecSrc = 6'd40; nvecPrio = 4'd7;
    busRd(16, got);
    check("R11 normal vector word", 256'(got), 256'(32'h0028_0007));
    check("R11 normal source cleared", 256'(pendingVec[40]), 256'(0));
    nvecValid = 1'b0;
    busRd(16, got);
    check("R11 empty normal vector", 256'(got), 256'(32'hFFFF_FFFF));

    // R12 fast vector read
    fvecValid = 1'b1; fvecSrc = 6'd63;
    busRd(17, got);
    check("R12 fast vector word", 256'(got), 256'(32'd63));
    check("R12 fast source cleared", 256'(pendingVec[63]), 256'(0));
    fvecValid = 1'b0;
    busRd(17, got);
    check("R12 empty fast vector", 256'(got), 256'(32'hFFFF_FFFF));

    // R13 clear beats same-cycle rising edge
    nvecValid = 1'b1; nvecSrc = 6'd33; nvecPrio = 4'd2;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 10'd16; irqIn[33] = 1'b1;
    @(negedge clk);
    busValid = 1'b0; nvecValid = 1'b0;
    check("R13 clear wins over edge", 256'(pendingVec[33]), 256'(0));

    // R14 read data holds
    busRd(64, got);
    repeat (3) @(negedge clk);
    check("R14 read data held", 256'(busRdata), 256'(32'h4));

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule